// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write port and read port run on separate clocks. Each port has an active-low enable and an active-low chip select, and both must be low for an access to happen. The read data comes from a register that changes only when a word is taken. A single asynchronous active-low reset clears both sides. While reset is held, each side captures a mode select.

In standard mode a word reaches the output register only after an explicit read. The write-side flag is an active-low "not full" indication. The read-side flag is an active-low "empty" indication: it is high while words are waiting. In fall-through mode the first word written into an empty buffer moves into the output register without any read request. The write-side flag then becomes an active-high "no room" indication. The read-side flag becomes an active-high "no word presented" indication, which is high while the output register holds no unread word.

Pointers cross between the two clock domains as Gray code through two-flop synchronizers. This sets the flag latencies given below.

Top module: `twin_mode_fifo`

## Requirements
- R1: A write stores `wr_data` on a rising `wr_clk` edge only when `wr_en_n` and `wr_cs_n` are both 0 and the storage is not full. A write request while full is ignored and does not disturb stored words.
- R2: A read is taken on a rising `rd_clk` edge only when `rd_en_n` and `rd_cs_n` are both 0 and a word is available. Words leave in the order they were written, and a read request while empty is ignored.
- R3: On an edge with no read, `rd_data` keeps its previous value. The one exception is the automatic load in fall-through mode (R7).
- R4: In standard mode (`fwft_sel`=0 during reset), `wr_flag` is 0 exactly when 16 words (DEPTH) are stored. After a read frees a location, it returns to 1 on the second `wr_clk` edge after that read.
- R5: In fall-through mode (`fwft_sel`=1 during reset), `wr_flag` is 1 when the memory is full, and it returns to 0 on the second `wr_clk` edge after a read frees a location. Because the output register holds one word, the buffer accepts DEPTH+1 (17) words.
- R6: In standard mode, `rd_flag` is 0 when no word is stored, including right after the read that takes the last word. After a write into the empty buffer, it goes to 1 on the second `rd_clk` edge after the write.
- R7: In fall-through mode, the first word written into an empty buffer appears on `rd_data` at the third rising `rd_clk` edge after the write, and `rd_flag` drops to 0 at the same edge. No read request is needed for this.
- R8: In fall-through mode, `rd_flag` goes to 1 on the edge of a read that takes the last presented word. Each word after the first presented one needs an explicit read.
- R9: The mode is captured only while `rst_n` is 0, and changes to `fwft_sel` after reset have no effect. Reset empties the buffer. After reset, `wr_flag` and `rd_flag` are 1 and 0 in standard mode, and 0 and 1 in fall-through mode.
- R10: A chip select held at 1 blocks its port even when the matching enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Mode select captured during reset: 0 standard, 1 fall-through |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_cs_n | input | 1 | Active-low write chip select |
| wr_data | input | 20 | Word to store |
| wr_flag | output | 1 | Standard mode: 0 when full; fall-through mode: 1 when full |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Active-low read enable |
| rd_cs_n | input | 1 | Active-low read chip select |
| rd_data | output | 20 | Registered output word |
| rd_flag | output | 1 | Standard mode: 0 when empty; fall-through mode: 1 when no word is presented |

## Verification
A corrupted pointer or synchronizer stage shows up at the ports within a few clocks: a flag edge lands one or more cycles early or late, or a word comes out of order. The bench therefore samples each flag on the exact edge that the two-stage crossing predicts. A wrongly latched mode reverses the polarity of both flags straight after reset. A broken full or empty guard shows up as one extra word, or a repeated word, when the buffer is drained.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
module fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
module fifo_mem #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
  import fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [AW:0]   rgray_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wflag
);
  fifo_mode_e  mode_q;
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic        full;
  logic        wr_go;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= fifo_mode_e'(mode_i);
  end

  always_comb begin
    full    = (wgray_q == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
    wr_go   = !wen_n && !wcs_n && !full;
    wbin_d  = wbin_q + 1'b1;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_go) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign we    = wr_go;
  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign wflag = (mode_q == MODE_FWFT) ? full : !full;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (wbin_q == $past(wbin_q)));
  p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
  import fifo_pkg::*;
#(
  parameter int W  = 20,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          ren_n,
  input  logic          rcs_n,
  input  logic [AW:0]   wgray_sync,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  rd_data,
  output logic          rflag
);
  fifo_mode_e  mode_q;
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [W-1:0] dout_q;
  logic        out_valid_q, out_valid_d;
  logic        mem_empty, rd_req, fwft, load;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= fifo_mode_e'(mode_i);
  end

  always_comb begin
    fwft      = (mode_q == MODE_FWFT);
    mem_empty = (rgray_q == wgray_sync);
    rd_req    = !ren_n && !rcs_n;
    if (fwft) load = !mem_empty && (!out_valid_q || rd_req);
    else      load = rd_req && !mem_empty;
    rbin_d  = rbin_q + 1'b1;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    out_valid_d = out_valid_q;
    if (fwft) begin
      if (load)        out_valid_d = 1'b1;
      else if (rd_req) out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q      <= '0;
      rgray_q     <= '0;
      dout_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      if (load) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
        dout_q  <= mem_rdata;
      end
      out_valid_q <= out_valid_d;
    end
  end

  assign raddr   = rbin_q[AW-1:0];
  assign rgray   = rgray_q;
  assign rd_data = dout_q;
  assign rflag   = fwft ? !out_valid_q : !mem_empty;

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_empty |=> (rbin_q == $past(rbin_q)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !(fwft && !out_valid_q)) |=> $stable(rd_data));
  p_fwft_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !out_valid_q && !mem_empty) |=> !rflag);
  p_last_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && out_valid_q && rd_req && mem_empty) |=> rflag);
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/twin_mode_fifo.sv
`timescale 1ns/1ps
module twin_mode_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         rst_n,
  input  logic         fwft_sel,
  input  logic         wr_clk,
  input  logic         wr_en_n,
  input  logic         wr_cs_n,
  input  logic [W-1:0] wr_data,
  output logic         wr_flag,
  input  logic         rd_clk,
  input  logic         rd_en_n,
  input  logic         rd_cs_n,
  output logic [W-1:0] rd_data,
  output logic         rd_flag
);
  logic          wrst_n, rrst_n;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_rs, rgray_ws;
  logic [W-1:0]  mem_rdata;

  fifo_sync #(.W(1)) u_wrst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  fifo_sync #(.W(1)) u_rrst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  fifo_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws));
  fifo_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs));

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .mode_i(fwft_sel),
    .wen_n(wr_en_n), .wcs_n(wr_cs_n), .rgray_sync(rgray_ws),
    .we(we), .waddr(waddr), .wgray(wgray), .wflag(wr_flag)
  );

  fifo_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  fifo_rd_ctl #(.W(W), .AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .mode_i(fwft_sel),
    .ren_n(rd_en_n), .rcs_n(rd_cs_n), .wgray_sync(wgray_rs),
    .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rflag(rd_flag)
  );
endmodule

// File: tb/sim_twin_mode_fifo.sv
`timescale 1ns/1ps
module sim_twin_mode_fifo;
  logic        clk = 1'b0;
  logic        rst_n, fwft_sel;
  logic        wr_en_n, wr_cs_n, rd_en_n, rd_cs_n;
  logic [19:0] wr_data;
  logic        wr_flag, rd_flag;
  logic [19:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;
  bit timeout = 0;

  always #2.5 clk = ~clk;

  twin_mode_fifo u0 (
    .rst_n(rst_n), .fwft_sel(fwft_sel),
    .wr_clk(clk), .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n), .wr_data(wr_data), .wr_flag(wr_flag),
    .rd_clk(clk), .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .rd_data(rd_data), .rd_flag(rd_flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(logic [19:0] d, logic cs_n);
    wr_data = d; wr_en_n = 1'b0; wr_cs_n = cs_n;
    @(negedge clk);
    wr_en_n = 1'b1; wr_cs_n = 1'b1;
  endtask

  task automatic pop(logic cs_n);
    rd_en_n = 1'b0; rd_cs_n = cs_n;
    @(negedge clk);
    rd_en_n = 1'b1; rd_cs_n = 1'b1;
  endtask

  task automatic do_reset(logic mode);
    rst_n = 1'b0; fwft_sel = mode;
    wr_en_n = 1'b1; wr_cs_n = 1'b1; rd_en_n = 1'b1; rd_cs_n = 1'b1; wr_data = '0;
    idle(4);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_std_basic();
    do_reset(1'b0);
    chk("R9 std reset wr_flag", wr_flag, 1);
    chk("R9 std reset rd_flag", rd_flag, 0);
    push(20'hA1A1, 1'b0);
    chk("R6 flag after write edge", rd_flag, 0);
    idle(1); chk("R6 flag one edge later", rd_flag, 0);
    idle(1); chk("R6 flag two edges later", rd_flag, 1);
    chk("R2 no read without request", rd_data, 0);
    pop(1'b0);
    chk("R2 read data", rd_data, 20'hA1A1);
    chk("R6 empty after last read", rd_flag, 0);
    pop(1'b0);
    chk("R2 read while empty ignored", rd_data, 20'hA1A1);
  endtask

  task automatic t_std_fill();
    do_reset(1'b0);
    for (int i = 0; i < 16; i++) push(20'h100 + 20'(i), 1'b0);
    chk("R4 full flag low", wr_flag, 0);
    push(20'hDEAD, 1'b0);
    push(20'hBEEF, 1'b0);
    idle(3);
    pop(1'b0);
    chk("R2 first word", rd_data, 20'h100);
    chk("R4 flag still low at edge", wr_flag, 0);
    idle(1); chk("R4 flag low one edge later", wr_flag, 0);
    idle(1); chk("R4 flag back high", wr_flag, 1);
    for (int i = 1; i < 16; i++) begin
      pop(1'b0);
      chk("R1 R2 order after overflow attempt", rd_data, 20'h100 + 20'(i));
    end
    chk("R1 no extra word stored", rd_flag, 0);
    pop(1'b0);
    chk("R3 data held on ignored read", rd_data, 20'h10F);
  endtask

  task automatic t_chip_select();
    do_reset(1'b0);
    push(20'h5555, 1'b1);
    idle(4);
    chk("R10 write blocked by cs", rd_flag, 0);
    push(20'h7777, 1'b0);
    idle(3);
    pop(1'b1);
    chk("R10 read blocked by cs", rd_data, 0);
    chk("R10 word still pending", rd_flag, 1);
    idle(2);
    chk("R3 idle keeps data", rd_data, 0);
    pop(1'b0);
    chk("R10 read with cs", rd_data, 20'h7777);
  endtask

  task automatic t_fwft_basic();
    do_reset(1'b1);
    fwft_sel = 1'b0;
    chk("R9 fwft reset wr_flag", wr_flag, 0);
    chk("R9 fwft reset rd_flag", rd_flag, 1);
    push(20'h0C0DE, 1'b0);
    chk("R7 not yet at write edge", rd_flag, 1);
    idle(1); chk("R7 not yet edge 1", rd_flag, 1);
    idle(1); chk("R7 not yet edge 2", rd_flag, 1);
    idle(1); chk("R7 flag at third edge", rd_flag, 0);
    chk("R7 data at third edge", rd_data, 20'h0C0DE);
    push(20'h0F00D, 1'b0);
    idle(4);
    chk("R8 second word needs read", rd_data, 20'h0C0DE);
    pop(1'b0);
    chk("R8 second word read", rd_data, 20'h0F00D);
    chk("R8 word presented", rd_flag, 0);
    pop(1'b0);
    chk("R8 flag high after last taken", rd_flag, 1);
    chk("R3 data held after last", rd_data, 20'h0F00D);
    pop(1'b0);
    chk("R2 fwft read on empty ignored", rd_data, 20'h0F00D);
  endtask

  task automatic t_fwft_fill();
    do_reset(1'b1);
    fwft_sel = 1'b0;
    push(20'h200, 1'b0);
    idle(4);
    for (int i = 1; i < 17; i++) push(20'h200 + 20'(i), 1'b0);
    chk("R5 full flag high", wr_flag, 1);
    chk("R9 mode kept after input change", rd_flag, 0);
    push(20'hBAD, 1'b0);
    idle(3);
    pop(1'b0);
    chk("R5 word after first", rd_data, 20'h201);
    chk("R5 flag high at edge", wr_flag, 1);
    idle(1); chk("R5 flag high one edge later", wr_flag, 1);
    idle(1); chk("R5 flag low two edges later", wr_flag, 0);
    for (int i = 2; i < 17; i++) begin
      pop(1'b0);
      chk("R5 R2 order", rd_data, 20'h200 + 20'(i));
    end
    chk("R8 last word presented", rd_flag, 0);
    pop(1'b0);
    chk("R1 R8 no extra word", rd_flag, 1);
  endtask

  initial begin
    fork
      begin
        t_std_basic();
        t_std_fill();
        t_chip_select();
        t_fwft_basic();
        t_fwft_fill();
      end
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule